// File: doc/BRIEF.md
# USB End-of-Packet Detector

This block is a passive monitor for a full-speed or low-speed USB segment. Each cycle of the recovered bit clock it receives one sample of the line state (J, K, single-ended zero or the illegal SE1) and a speed-select level. It never drives the bus. From these samples it finds the end of each packet: a run of SE0 samples that is long enough, followed by a J.

An SE0 run that ends in anything other than a proper J still produces an end-of-packet pulse, so that downstream framing can pick up the next packet. That end is marked as malformed in two ways. The state code shows a separate value, and a sticky possible-bad-EOP flag is raised, which software or a trigger can sample later. The three-bit state register is brought out unchanged for debug. The minimum SE0 length counts as a number of samples. It is derived from nanosecond parameters for each speed.

Top module: `usb_eop_detector`

## Requirements
- R1: After synchronous reset, `state_o` is 000, `eop_o` is 0 and `bad_eop_o` is 0.
- R2: Line codes on `line_i` are 00 SE0, 01 J, 10 K, 11 SE1. In idle (000) with `low_speed_i` = 0, an SE0 sample moves the state to 001. A second consecutive SE0 moves it to 010, and a third or later SE0 gives 110.
- R3: In idle with `low_speed_i` = 1, an SE0 sample moves the state to 100. A second SE0 gives 101, and a third or later gives 110.
- R4: A J sample that follows a qualified SE0 run moves the state to 011 and raises `eop_o` for exactly one clock. On the next clock the state returns to 000.
- R5: An SE0 run followed by K or SE1 moves the state to 111, raises `eop_o` for one clock and sets `bad_eop_o`. The state then returns to 000.
- R6: A run is qualified when its sample count reaches ceil(FS_MIN_SE0_NS / FS_BIT_NS) at full speed, or ceil(LS_MIN_SE0_NS / LS_BIT_NS) at low speed. A J after a shorter run is treated as in R5: state 111, a pulse, and the flag is set.
- R7: `bad_eop_o` stays set until a K sample is seen in idle (a packet start) or `bad_clr_i` is high at a clock edge. A new bad end in the same cycle as `bad_clr_i` wins, and the flag stays set.
- R8: The line sample taken while the state is 011 or 111 has no effect: the next state is 000 whatever it is. `low_speed_i` is only looked at on the first SE0 sample of a run.
- R9: In idle, J, K and SE1 samples leave the state at 000 and `eop_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock, one line sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 2 | Sampled line state: 00 SE0, 01 J, 10 K, 11 SE1 |
| low_speed_i | input | 1 | 1 selects low-speed timing for the next SE0 run |
| bad_clr_i | input | 1 | Synchronous clear of the possible-bad-EOP flag |
| eop_o | output | 1 | One-clock end-of-packet pulse (good or bad end) |
| bad_eop_o | output | 1 | Sticky possible-bad-EOP flag |
| state_o | output | 3 | Encoded detector state, for debug |

## Verification
The bench builds the detector with a full-speed bit time of 25 ns and a low-speed bit time of 150 ns. It keeps the 60 ns and 300 ns minimums. This makes a run qualified at three samples at full speed and at two samples at low speed. With the default bit times, a single sample qualifies at either speed, so a J after a short run can never be seen. The chosen values bring that case within reach for both speeds, and they still let runs pass through the shared long-SE0 state before a valid end.

// File: rtl/eopdet_pkg.sv
package eopdet_pkg;

  typedef enum logic [1:0] {
    LN_SE0 = 2'b00,
    LN_J   = 2'b01,
    LN_K   = 2'b10,
    LN_SE1 = 2'b11
  } line_t;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'b000,
    ST_FS_SE0A  = 3'b001,
    ST_FS_SE0B  = 3'b010,
    ST_EOP_OK   = 3'b011,
    ST_LS_SE0A  = 3'b100,
    ST_LS_SE0B  = 3'b101,
    ST_SE0_LONG = 3'b110,
    ST_EOP_BAD  = 3'b111
  } eop_state_t;

  // Samples needed so that the SE0 run covers min_ns at the given bit time.
  function automatic int samples_for(input int min_ns, input int bit_ns);
    int q;
    q = (min_ns + bit_ns - 1) / bit_ns;
    if (q < 1) q = 1;
    return q;
  endfunction

endpackage

// File: rtl/eopdet_run_ctr.sv
module eopdet_run_ctr #(
  parameter int MAXQ = 1,
  parameter int CW   = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          track_i,
  input  logic          se0_i,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] SAT = CW'(MAXQ);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (!track_i || !se0_i) cnt_q <= '0;
    else if (cnt_q != SAT)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R6: the run length never passes the largest threshold it must resolve
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= SAT);

endmodule

// File: rtl/eopdet_fsm.sv
module eopdet_fsm
  import eopdet_pkg::*;
#(
  parameter int FS_QUAL = 1,
  parameter int LS_QUAL = 1,
  parameter int CW      = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    line_i,
  input  logic          ls_i,
  input  logic [CW-1:0] run_len_i,
  output logic [2:0]    state_o,
  output logic          eop_o,
  output logic          enter_bad_o,
  output logic          track_o,
  output logic          idle_o
);

  eop_state_t state_q, state_d;
  logic       slow_q, slow_d;
  logic       eop_q;
  logic       qual;
  line_t      ln;

  assign ln   = line_t'(line_i);
  assign qual = slow_q ? (int'(run_len_i) >= LS_QUAL) : (int'(run_len_i) >= FS_QUAL);

  always_comb begin
    state_d = state_q;
    slow_d  = slow_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ln == LN_SE0) begin
          slow_d  = ls_i;
          state_d = ls_i ? ST_LS_SE0A : ST_FS_SE0A;
        end
      end
      ST_FS_SE0A, ST_FS_SE0B, ST_LS_SE0A, ST_LS_SE0B, ST_SE0_LONG: begin
        if (ln == LN_SE0) begin
          case (state_q)
            ST_FS_SE0A: state_d = ST_FS_SE0B;
            ST_LS_SE0A: state_d = ST_LS_SE0B;
            default:    state_d = ST_SE0_LONG;
          endcase
        end else if (ln == LN_J && qual) begin
          state_d = ST_EOP_OK;
        end else begin
          state_d = ST_EOP_BAD;
        end
      end
      ST_EOP_OK, ST_EOP_BAD: state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      slow_q  <= 1'b0;
      eop_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      slow_q  <= slow_d;
      eop_q   <= (state_d == ST_EOP_OK) || (state_d == ST_EOP_BAD);
    end
  end

  assign state_o     = state_q;
  assign eop_o       = eop_q;
  assign enter_bad_o = (state_d == ST_EOP_BAD);
  assign track_o     = (state_q != ST_EOP_OK) && (state_q != ST_EOP_BAD);
  assign idle_o      = (state_q == ST_IDLE);

  // R4: the end pulse lasts a single clock
  assert_pulse_narrow_R4: assert property (@(posedge clk) disable iff (rst)
    eop_q |=> !eop_q);

  // R4: one clock after an end the detector is back in idle
  assert_back_idle_R4: assert property (@(posedge clk) disable iff (rst)
    eop_q |=> state_q == ST_IDLE);

  // R2: the shared long-SE0 state is only reached from a second SE0 state or itself
  assert_long_entry_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SE0_LONG) |->
      ($past(state_q) == ST_FS_SE0B || $past(state_q) == ST_LS_SE0B ||
       $past(state_q) == ST_SE0_LONG));

  // R3: the second slow SE0 state always follows the first slow SE0 state
  assert_slow_order_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LS_SE0B) |-> $past(state_q) == ST_LS_SE0A);

endmodule

// File: rtl/eopdet_flag.sv
module eopdet_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic pkt_start_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)                       flag_q <= 1'b0;
    else if (set_i)                flag_q <= 1'b1;
    else if (pkt_start_i || clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R7: a new bad end outranks a clear in the same cycle
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_q);

endmodule

// File: rtl/usb_eop_detector.sv
module usb_eop_detector
  import eopdet_pkg::*;
#(
  parameter int FS_BIT_NS     = 83,
  parameter int LS_BIT_NS     = 667,
  parameter int FS_MIN_SE0_NS = 60,
  parameter int LS_MIN_SE0_NS = 300
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] line_i,
  input  logic       low_speed_i,
  input  logic       bad_clr_i,
  output logic       eop_o,
  output logic       bad_eop_o,
  output logic [2:0] state_o
);

  localparam int FS_QUAL = samples_for(FS_MIN_SE0_NS, FS_BIT_NS);
  localparam int LS_QUAL = samples_for(LS_MIN_SE0_NS, LS_BIT_NS);
  localparam int MAXQ    = (FS_QUAL > LS_QUAL) ? FS_QUAL : LS_QUAL;
  localparam int CW      = $clog2(MAXQ + 1);

  logic [CW-1:0] run_len;
  logic          track, idle, enter_bad;
  logic          pkt_start;

  eopdet_run_ctr #(.MAXQ(MAXQ), .CW(CW)) u_run (
    .clk     (clk),
    .rst     (rst),
    .track_i (track),
    .se0_i   (line_i == LN_SE0),
    .cnt_o   (run_len)
  );

  eopdet_fsm #(.FS_QUAL(FS_QUAL), .LS_QUAL(LS_QUAL), .CW(CW)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .line_i      (line_i),
    .ls_i        (low_speed_i),
    .run_len_i   (run_len),
    .state_o     (state_o),
    .eop_o       (eop_o),
    .enter_bad_o (enter_bad),
    .track_o     (track),
    .idle_o      (idle)
  );

  assign pkt_start = idle && (line_i == LN_K);

  eopdet_flag u_flag (
    .clk         (clk),
    .rst         (rst),
    .set_i       (enter_bad),
    .pkt_start_i (pkt_start),
    .clr_i       (bad_clr_i),
    .flag_o      (bad_eop_o)
  );

  // R5: a malformed end always carries both the pulse and the flag
  assert_bad_tagged_R5: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_EOP_BAD) |-> (eop_o && bad_eop_o));

  // R9: leaving idle only happens on an SE0 sample
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (idle && line_i != LN_SE0) |=> (state_o == ST_IDLE && !eop_o));

endmodule

// File: tb/sim_usb_eop_detector.sv
module sim_usb_eop_detector;

  localparam logic [1:0] SE0 = 2'b00;
  localparam logic [1:0] LJ  = 2'b01;
  localparam logic [1:0] LK  = 2'b10;
  localparam logic [1:0] SE1 = 2'b11;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] line = LJ;
  logic       low = 1'b0;
  logic       clr = 1'b0;
  logic       eop, bad;
  logic [2:0] st;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  usb_eop_detector #(
    .FS_BIT_NS(25), .LS_BIT_NS(150), .FS_MIN_SE0_NS(60), .LS_MIN_SE0_NS(300)
  ) u0 (
    .clk(clk), .rst(rst), .line_i(line), .low_speed_i(low), .bad_clr_i(clr),
    .eop_o(eop), .bad_eop_o(bad), .state_o(st)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect3(input string tag, input int s, input int e, input int b);
    check({tag, " state"}, int'(st), s);
    check({tag, " eop"}, int'(eop), e);
    check({tag, " bad"}, int'(bad), b);
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(input logic [1:0] ln, input logic ls);
    line = ln;
    low  = ls;
    @(negedge clk);
  endtask

  task automatic t_reset();
    expect3("R1 reset", 0, 0, 0);
  endtask

  task automatic t_idle_quiet();
    step(LJ, 0);  expect3("R9 idle J", 0, 0, 0);
    step(LK, 0);  expect3("R9 idle K", 0, 0, 0);
    step(SE1, 0); expect3("R9 idle SE1", 0, 0, 0);
  endtask

  task automatic t_fs_valid();
    step(SE0, 0); expect3("R2 fs first", 1, 0, 0);
    step(SE0, 0); expect3("R2 fs second", 2, 0, 0);
    step(SE0, 0); expect3("R2 fs third", 6, 0, 0);
    step(SE0, 0); expect3("R2 fs fourth", 6, 0, 0);
    step(LJ, 0);  expect3("R4 fs valid end", 3, 1, 0);
    step(LJ, 0);  expect3("R4 back to idle", 0, 0, 0);
  endtask

  task automatic t_fs_short();
    step(SE0, 0); step(SE0, 0);
    step(LJ, 0);  expect3("R6 fs short run", 7, 1, 1);
    step(LJ, 0);  expect3("R7 flag held", 0, 0, 1);
    step(LJ, 0);  expect3("R7 flag held idle", 0, 0, 1);
    step(LK, 0);  expect3("R7 packet start clears", 0, 0, 0);
  endtask

  task automatic t_ls();
    step(SE0, 1); expect3("R3 ls first", 4, 0, 0);
    step(SE0, 1); expect3("R3 ls second", 5, 0, 0);
    step(LJ, 1);  expect3("R4 ls valid end", 3, 1, 0);
    step(LJ, 1);  expect3("R4 ls idle", 0, 0, 0);
    step(SE0, 1); step(SE0, 1);
    step(SE0, 1); expect3("R3 ls third", 6, 0, 0);
    step(LJ, 1);  expect3("R4 ls long end", 3, 1, 0);
    step(LJ, 1);
    step(SE0, 1);
    step(LJ, 1);  expect3("R6 ls short run", 7, 1, 1);
    step(LJ, 1);
    clr = 1'b1;
    step(LJ, 0);  expect3("R7 clear input", 0, 0, 0);
    clr = 1'b0;
  endtask

  task automatic t_nonj();
    step(SE0, 0); step(SE0, 0); step(SE0, 0);
    step(LK, 0);  expect3("R5 K after SE0", 7, 1, 1);
    step(LJ, 0);  expect3("R5 idle after bad", 0, 0, 1);
    step(SE0, 0); step(SE0, 0); step(SE0, 0);
    clr = 1'b1;
    step(SE1, 0); expect3("R5 SE1 after SE0 R7 set wins", 7, 1, 1);
    clr = 1'b0;
    step(LJ, 0);
    step(LK, 0);  expect3("R7 cleared by K", 0, 0, 0);
  endtask

  task automatic t_ignore();
    step(SE0, 0); step(SE0, 0); step(SE0, 0);
    step(LJ, 0);  expect3("R8 valid end", 3, 1, 0);
    step(SE0, 0); expect3("R8 SE0 ignored at end", 0, 0, 0);
    step(LJ, 0);  expect3("R8 still idle", 0, 0, 0);
    step(SE0, 0); expect3("R8 fs start", 1, 0, 0);
    step(SE0, 1); expect3("R8 speed held", 2, 0, 0);
    step(SE0, 1); expect3("R8 speed held long", 6, 0, 0);
    step(LJ, 1);  expect3("R8 end fs", 3, 1, 0);
    step(LJ, 0);
  endtask

  initial begin : watchdog
    repeat (10000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_idle_quiet();
    t_fs_valid();
    t_fs_short();
    t_ls();
    t_nonj();
    t_ignore();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule